// File: doc/BRIEF.md
# Cache ECC Error Reporting Registers

This block is the status and control register file that sits beside a banked, set-associative last-level cache and records the ECC events that the cache's codecs detect. Four event sources are watched: correctable and uncorrectable errors in the tag directory, and correctable and uncorrectable errors in the data array. Each source has its own channel, made of a captured 64-bit failing address, a saturating event counter and a dedicated interrupt line.

Each event arrives as a one-cycle pulse with the address that failed. The host reads the captured address and then the counter. Reading the counter acknowledges the interrupt of that channel. The register file also reports the cache geometry, which is fixed by parameters. It holds a way-limit value, and it decodes writes to an error-injection register into a one-cycle command for the cache's fault-injection logic.

The host port is a plain 32-bit register interface. A read strobe returns data on `reg_rdata` one cycle later, and the value holds until the next read.

Top module: `cache_ecc_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released, all interrupts, all counters, `inj_pulse`, `way_max` and `reg_rdata` are zero.
- R2: An event on channel c captures its address. The low 32 bits read at offset 0x100+0x20*c and the high 32 bits at 0x104+0x20*c. Channel 0 is directory-correctable, 1 is directory-uncorrectable, 2 is data-correctable and 3 is data-uncorrectable. Other channels are not affected.
- R3: The counter of channel c reads at offset 0x108+0x20*c, zero-extended. It rises by one per event and stays at all-ones (2^CNT_W-1) once reached.
- R4: `irq[c]` is high from the cycle after an event on channel c. It stays high until the counter of channel c is read.
- R5: A read of channel c's counter clears `irq[c]` and leaves the counter value unchanged. Reads of the address registers clear nothing.
- R6: When an event and a counter read hit the same channel in one cycle, the event wins. The address is captured, the counter increments and the interrupt stays high. The read returns the count from before the event.
- R7: Offset 0x00 reads the geometry. Bits 7:0 hold NBANKS, bits 15:8 hold NWAYS, bits 23:16 hold SETS_LOG2 and bits 31:24 hold BLK_LOG2.
- R8: Offset 0x08 reads the way limit in bits 7:0, with the upper bits zero. A write there stores wdata[7:0] clamped to NWAYS-1, and that value drives `way_max`.
- R9: A write to offset 0x40 with a value in 0x00–0xFE or 0x10000–0x100FE raises `inj_pulse` for exactly one cycle, the cycle after the write. `inj_data_sel` then equals wdata[16] and `inj_bit` equals wdata[7:0].
- R10: A write to offset 0x40 with any other value raises no `inj_pulse`.
- R11: Reads of unmapped offsets return zero. Writes to the geometry, address and counter registers change nothing.
- R12: `reg_rdata` changes only in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| ev_valid | input | 4 | One-cycle event pulse per channel |
| ev_addr | input | 256 | Failing address per channel, channel c in bits 64c+63:64c |
| irq | output | 4 | Interrupt per channel |
| way_max | output | 8 | Index of the largest enabled way |
| inj_pulse | output | 1 | One-cycle error-injection command |
| inj_data_sel | output | 1 | Injection target: 1 data array, 0 directory |
| inj_bit | output | 8 | Bit position to corrupt |

## Verification
The case that is hardest to reach is a counter read and a new event landing on the same channel in the same clock. The bench gets there by first raising that channel's interrupt. It then drives the event pulse and the counter read strobe at the same falling edge. It checks that the interrupt survives, that the old count is returned and that a second read shows the incremented count. Counter saturation needs a burst longer than the counter range, so the bench builds the design with a 4-bit counter. It sends a run of twenty events into one channel. The injection decoder is swept over every value near both accepted windows and their edges.

// File: rtl/cache_ecc_pkg.sv
// Shared constants of the cache ECC register block: channel count, the
// width of a failing address and the register offsets the host decodes.
package cache_ecc_pkg;
    localparam int NUM_CH    = 4;   // dir-CE, dir-UE, data-CE, data-UE
    localparam int EV_ADDR_W = 64;
    localparam int REG_W     = 32;
    localparam int OFF_W     = 12;

    localparam logic [OFF_W-1:0] OFF_GEOM  = 12'h000;
    localparam logic [OFF_W-1:0] OFF_WAYEN = 12'h008;
    localparam logic [OFF_W-1:0] OFF_INJ   = 12'h040;

    // Channel window: 0x100 + 0x20*c, fields at +0x0, +0x4, +0x8.
    localparam logic [4:0] CH_WIN_TAG = 5'b00010;   // reg_addr[11:7]
    localparam logic [4:0] FLD_ADDR_LO = 5'h00;
    localparam logic [4:0] FLD_ADDR_HI = 5'h04;
    localparam logic [4:0] FLD_COUNT   = 5'h08;
endpackage

// File: rtl/ecc_err_chan.sv
// One ECC error channel. It captures the failing address, counts events
// with saturation and holds an interrupt until the count is acknowledged.
// Assumes ev is a single-cycle pulse. An event in the same cycle as an
// acknowledge takes precedence over the acknowledge.
module ecc_err_chan #(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ack,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Capture the address, bump the counter and set or clear the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            irq    <= 1'b0;
        end else if (ev) begin
            addr_q <= ev_addr;
            if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
            irq    <= 1'b1;
        end else if (ack) begin
            irq    <= 1'b0;
        end
    end

    assert_addr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> addr_q == $past(ev_addr));
    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
    assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> irq);
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ev) |=> (!irq && $stable(cnt_q)));
    assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
endmodule

// File: rtl/ecc_inject_dec.sv
// Error-injection command decoder. It checks a written value against the
// two accepted windows and emits a one-cycle command carrying the target
// select and the bit index. Rejected values produce nothing.
module ecc_inject_dec #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          pulse,
    output logic          data_sel,
    output logic [7:0]    bit_idx
);
    localparam int UPPER_W = DW - 8;
    localparam logic [UPPER_W-1:0] UP_DIR  = '0;
    localparam logic [UPPER_W-1:0] UP_DATA = UPPER_W'(1) << (16 - 8);

    logic upper_ok, accept;

    // Decide whether the written value falls inside an accepted window.
    always_comb begin
        upper_ok = (wdata[DW-1:8] == UP_DIR) || (wdata[DW-1:8] == UP_DATA);
        accept   = upper_ok && (wdata[7:0] != 8'hFF);
    end

    // Register the command; the fields update only on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse    <= 1'b0;
            data_sel <= 1'b0;
            bit_idx  <= '0;
        end else begin
            pulse <= wr_en && accept;
            if (wr_en && accept) begin
                data_sel <= wdata[16];
                bit_idx  <= wdata[7:0];
            end
        end
    end

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(wr_en));
    assert_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> !pulse);
endmodule

// File: rtl/cache_ecc_regs.sv
// Register file for last-level cache ECC reporting. It decodes the host
// register port, instantiates one channel per error class, holds the way
// limit, returns read data one cycle after the read strobe, and
// acknowledges a channel's interrupt when its counter is read.
// Assumes CNT_W <= 32 and that the ways fit in 8 bits.
module cache_ecc_regs
    import cache_ecc_pkg::*;
#(
    parameter int NBANKS    = 4,
    parameter int NWAYS     = 16,
    parameter int SETS_LOG2 = 10,
    parameter int BLK_LOG2  = 6,
    parameter int CNT_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [OFF_W-1:0]              reg_addr,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic [REG_W-1:0]              reg_rdata,
    input  logic [NUM_CH-1:0]             ev_valid,
    input  logic [NUM_CH*EV_ADDR_W-1:0]   ev_addr,
    output logic [NUM_CH-1:0]             irq,
    output logic [7:0]                    way_max,
    output logic                          inj_pulse,
    output logic                          inj_data_sel,
    output logic [7:0]                    inj_bit
);
    localparam logic [7:0] WAY_TOP = 8'(NWAYS - 1);
    localparam logic [REG_W-1:0] GEOM_VAL =
        {8'(BLK_LOG2), 8'(SETS_LOG2), 8'(NWAYS), 8'(NBANKS)};

    logic [EV_ADDR_W-1:0] ch_addr [NUM_CH];
    logic [CNT_W-1:0]     ch_cnt  [NUM_CH];
    logic [NUM_CH-1:0]    ch_ack;
    logic                 ch_hit;
    logic [1:0]           ch_sel;
    logic [4:0]           ch_fld;
    logic [REG_W-1:0]     rd_mux;
    logic [REG_W-1:0]     cnt_ext;

    // Split the offset into channel window, channel index and field.
    always_comb begin
        ch_hit = (reg_addr[11:7] == CH_WIN_TAG);
        ch_sel = reg_addr[6:5];
        ch_fld = reg_addr[4:0];
    end

    // Per-channel logic, one instance per error class.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_ack[c] = reg_rd && ch_hit && (ch_sel == 2'(c)) && (ch_fld == FLD_COUNT);
        ecc_err_chan #(.ADDR_W(EV_ADDR_W), .CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (ev_valid[c]),
            .ev_addr (ev_addr[c*EV_ADDR_W +: EV_ADDR_W]),
            .ack     (ch_ack[c]),
            .addr_q  (ch_addr[c]),
            .cnt_q   (ch_cnt[c]),
            .irq     (irq[c])
        );
    end

    // Injection command decoder.
    ecc_inject_dec #(.DW(REG_W)) u_inj (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr && (reg_addr == OFF_INJ)),
        .wdata    (reg_wdata),
        .pulse    (inj_pulse),
        .data_sel (inj_data_sel),
        .bit_idx  (inj_bit)
    );

    // Way-limit register, clamped to the last way on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            way_max <= '0;
        else if (reg_wr && reg_addr == OFF_WAYEN)
            way_max <= (reg_wdata[7:0] > WAY_TOP) ? WAY_TOP : reg_wdata[7:0];
    end

    // Read multiplexer over all mapped offsets; everything else reads zero.
    always_comb begin
        cnt_ext = '0;
        cnt_ext[CNT_W-1:0] = ch_cnt[ch_sel];
        rd_mux = '0;
        if (ch_hit) begin
            case (ch_fld)
                FLD_ADDR_LO: rd_mux = ch_addr[ch_sel][31:0];
                FLD_ADDR_HI: rd_mux = ch_addr[ch_sel][63:32];
                FLD_COUNT:   rd_mux = cnt_ext;
                default:     rd_mux = '0;
            endcase
        end else if (reg_addr == OFF_GEOM) begin
            rd_mux = GEOM_VAL;
        end else if (reg_addr == OFF_WAYEN) begin
            rd_mux = {24'h0, way_max};
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
    assert_way_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        way_max <= WAY_TOP);
    assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_ack));
endmodule

// File: tb/tb_cache_ecc_regs.sv
// Self-checking bench: small configuration with a 4-bit counter.
module tb_cache_ecc_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [3:0]   ev_valid = '0;
    logic [255:0] ev_addr = '0;
    logic [3:0]   irq;
    logic [7:0]   way_max;
    logic         inj_pulse, inj_data_sel;
    logic [7:0]   inj_bit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int exp_cnt [4];
    logic [3:0] exp_irq;

    always #4 clk = ~clk;   // 125 MHz

    cache_ecc_regs #(.NBANKS(2), .NWAYS(8), .SETS_LOG2(6), .BLK_LOG2(5), .CNT_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid), .ev_addr(ev_addr),
        .irq(irq), .way_max(way_max), .inj_pulse(inj_pulse), .inj_data_sel(inj_data_sel),
        .inj_bit(inj_bit));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Read strobe for one cycle; data is checked at the following falling edge.
    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    function automatic logic [63:0] mk_addr(input int c, input int k);
        return {32'hA500_0000 + 32'(c), 32'h1234_0000 + 32'(k * 16 + c)};
    endfunction

    task automatic fire(input int c, input logic [63:0] a);
        @(negedge clk); ev_valid[c] = 1'b1; ev_addr[c*64 +: 64] = a;
        @(negedge clk); ev_valid = '0;
        exp_irq[c] = 1'b1;
        if (exp_cnt[c] < 15) exp_cnt[c]++;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        logic [63:0] a;
        for (int c = 0; c < 4; c++) exp_cnt[c] = 0;
        exp_irq = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 irq", {28'h0, irq}, 32'h0);
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 inj", {31'h0, inj_pulse}, 32'h0);
        check("R1 way", {24'h0, way_max}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            do_read(12'h108 + 12'(c * 32), d);
            check("R1 count", d, 32'h0);
        end

        // R7: geometry, R11: write to it ignored
        do_read(12'h000, d);
        check("R7 geometry", d, {8'd5, 8'd6, 8'd8, 8'd2});
        do_write(12'h000, 32'hFFFF_FFFF);
        do_read(12'h000, d);
        check("R11 geometry ro", d, {8'd5, 8'd6, 8'd8, 8'd2});

        // R2 R3 R4 R5: sweep every channel with several events
        for (int c = 0; c < 4; c++) begin
            for (int k = 1; k <= 3; k++) begin
                a = mk_addr(c, k);
                fire(c, a);
                check("R4 irq after event", {28'h0, irq}, {28'h0, exp_irq});
                do_read(12'h100 + 12'(c * 32), d);
                check("R2 addr low", d, a[31:0]);
                do_read(12'h104 + 12'(c * 32), d);
                check("R2 addr high", d, a[63:32]);
                check("R5 addr read keeps irq", {28'h0, irq}, {28'h0, exp_irq});
                do_read(12'h108 + 12'(c * 32), d);
                exp_irq[c] = 1'b0;
                check("R3 count", d, 32'(exp_cnt[c]));
                check("R5 count read clears irq", {28'h0, irq}, {28'h0, exp_irq});
                do_read(12'h108 + 12'(c * 32), d);
                check("R5 count kept", d, 32'(exp_cnt[c]));
            end
        end
        // R2: channels independent, earlier channels keep their address
        do_read(12'h100, d);
        check("R2 ch0 unchanged", d, mk_addr(0, 3)[31:0]);

        // R11: writes to channel registers ignored
        do_write(12'h108, 32'h5);
        do_write(12'h120, 32'hDEAD_BEEF);
        do_read(12'h108, d);
        check("R11 count ro", d, 32'(exp_cnt[0]));
        do_read(12'h120, d);
        check("R11 addr ro", d, mk_addr(1, 3)[31:0]);

        // R3: saturation on channel 3 with 20 events
        for (int k = 0; k < 20; k++) fire(3, mk_addr(3, 40 + k));
        do_read(12'h168, d);
        exp_irq[3] = 1'b0;
        check("R3 saturated", d, 32'hF);
        check("R4 irq cleared", {28'h0, irq}, {28'h0, exp_irq});

        // R6: event and count read on channel 1 in the same cycle
        fire(1, mk_addr(1, 7));
        @(negedge clk);
        reg_addr = 12'h128; reg_rd = 1'b1;
        ev_valid[1] = 1'b1; ev_addr[64 +: 64] = mk_addr(1, 9);
        @(negedge clk); reg_rd = 1'b0; ev_valid = '0;
        check("R6 old count returned", reg_rdata, 32'(exp_cnt[1]));
        exp_cnt[1]++;
        check("R6 irq survives", {31'h0, irq[1]}, 32'h1);
        do_read(12'h120, d);
        check("R6 address captured", d, mk_addr(1, 9)[31:0]);
        do_read(12'h128, d);
        check("R6 count incremented", d, 32'(exp_cnt[1]));
        check("R6 then cleared", {31'h0, irq[1]}, 32'h0);

        // R8: way limit with clamp
        for (int v = 0; v < 12; v++) begin
            do_write(12'h008, 32'hAB00_0000 | 32'(v));
            check("R8 way_max", {24'h0, way_max}, (v > 7) ? 32'd7 : 32'(v));
            do_read(12'h008, d);
            check("R8 way read", d, (v > 7) ? 32'd7 : 32'(v));
        end

        // R11: unmapped reads
        begin
            logic [11:0] um [7];
            um = '{12'h004, 12'h010, 12'h044, 12'h10C, 12'h180, 12'h1E8, 12'hFFC};
            for (int i = 0; i < 7; i++) begin
                do_read(um[i], d);
                check("R11 unmapped", d, 32'h0);
            end
        end

        // R12: rdata holds without a read strobe
        do_read(12'h000, d);
        repeat (3) @(negedge clk);
        check("R12 hold", reg_rdata, {8'd5, 8'd6, 8'd8, 8'd2});

        // R9 R10: sweep around both injection windows
        for (int w = 0; w < 3; w++) begin
            for (int lo = 0; lo < 512; lo += 1) begin
                logic [31:0] v;
                bit ok;
                v = (w == 0) ? 32'(lo) : (w == 1) ? 32'h10000 + 32'(lo) : 32'h20000 + 32'(lo);
                ok = (v < 32'hFF) || (v >= 32'h10000 && v < 32'h100FF);
                do_write(12'h040, v);
                check(ok ? "R9 pulse" : "R10 no pulse", {31'h0, inj_pulse}, {31'h0, ok});
                if (ok) begin
                    check("R9 sel", {31'h0, inj_data_sel}, {31'h0, v[16]});
                    check("R9 bit", {24'h0, inj_bit}, {24'h0, v[7:0]});
                end
                @(negedge clk);
                check("R9 one cycle", {31'h0, inj_pulse}, 32'h0);
            end
        end
        do_write(12'h044, 32'h5);
        check("R10 other offset", {31'h0, inj_pulse}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule